// File: doc/BRIEF.md
# Register Write-Lock Key Sequencer

This block protects a bank of 32-bit control registers from stray writes. It watches a simple synchronous register bus for writes to two lock registers. A write of any value to either lock register closes the gate. Once the gate is closed, writes to the protected registers are dropped.

Opening the gate again takes two specific 32-bit keys. The first key is written to the second lock register. The very next bus write must then place the second key in the first lock register. Any other order, any wrong value, or any write between the two keys sends the sequencer back to its waiting state, and the gate stays closed. Bus reads do not count as writes and do not break the sequence.

The block contains one small protected data-out register, so the gate can be observed. It also drives a `wr_permit` output that other protected registers can use as their write enable. The current lock state can be read back through the bus.

Top module: `wlock_guard`

## Requirements
- R1: After reset the block is unlocked: `wr_permit` is 1, lock register A reads 0 and the data-out register reads 0.
- R2: While unlocked, a write of any value to lock register A (offset 0x00) locks the block. From the next cycle on, `wr_permit` is 0.
- R3: While unlocked, a write of any value to lock register B (offset 0x7C) also locks the block.
- R4: A read of lock register A returns 1 in bit 0 when locked and 0 when unlocked, with all upper bits 0. A read of lock register B always returns 0.
- R5: A write to the data-out register (offset 0x0C) updates it while unlocked. While locked, the write is dropped and the old value is kept.
- R6: The block unlocks when 0xC0DE1248 is written to lock register B and the next bus write puts 0xC0DEFA73 into lock register A. The gate is open from the cycle after that second write.
- R7: While locked, the sequence restarts and the block stays locked if the write after the first key has the wrong value, targets any other address, or is a write to an unrelated register. A later correct second key alone, without a new first key, does not unlock.
- R8: While locked, writing the first key on its own neither unlocks nor changes the lock status that is read back. Other writes to the lock registers leave the block locked.
- R9: Bus reads placed between the first and second key do not break the unlock sequence.
- R10: A read of an address that is mapped to no register returns 0. With registered read data, the value appears one cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (8) | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W (32) | Read data (registered or combinational, set by RD_REG) |
| wr_permit | output | 1 | High while protected writes may take effect |

## Verification
The bench builds the block with RD_REG=1, the registered read path, and keeps the default 8-bit offsets and default keys. Registered reads let the bench place a read between the two key writes and still sample each value one cycle later. This tests that reads leave the sequencer state alone. The default offsets and keys expose every way the sequence can go wrong: a bad value, the wrong target register, and a write to another register between the keys. A reset applied while the block is locked is also checked.

// File: rtl/wlock_pkg.sv
package wlock_pkg;
   typedef enum logic [1:0] {
      LS_OPEN  = 2'd0,
      LS_SHUT  = 2'd1,
      LS_ARMED = 2'd2
   } lock_state_e;
endpackage

// File: rtl/wlock_keyseq.sv
module wlock_keyseq
   import wlock_pkg::*;
#(
   parameter int               DATA_W     = 32,
   parameter logic [DATA_W-1:0] KEY_FIRST  = 32'hC0DE1248,
   parameter logic [DATA_W-1:0] KEY_SECOND = 32'hC0DEFA73
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              hit_a,
   input  logic              hit_b,
   input  logic [DATA_W-1:0] wdata,
   output logic              locked,
   output logic              wr_permit
);
   lock_state_e state_q, state_d;

   if (KEY_FIRST == KEY_SECOND) begin : g_key_check
      $error("wlock_keyseq: the two keys must differ");
   end

   always_comb begin
      state_d = state_q;
      if (wr_en) begin
         unique case (state_q)
            LS_OPEN:  if (hit_a || hit_b) state_d = LS_SHUT;
            LS_SHUT:  if (hit_b && wdata == KEY_FIRST) state_d = LS_ARMED;
            LS_ARMED: state_d = (hit_a && wdata == KEY_SECOND) ? LS_OPEN : LS_SHUT;
            default:  state_d = LS_SHUT;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= LS_OPEN;
      else        state_q <= state_d;
   end

   assign locked    = (state_q != LS_OPEN);
   assign wr_permit = (state_q == LS_OPEN);

   assert_lock_by_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!locked && wr_en && hit_a) |=> locked);
   assert_lock_by_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!locked && wr_en && hit_b) |=> locked);
   assert_unlock_seq_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LS_ARMED && wr_en && hit_a && wdata == KEY_SECOND) |=> wr_permit);
   assert_stay_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !(state_q == LS_ARMED && wr_en && hit_a && wdata == KEY_SECOND))
      |=> locked);
   assert_first_key_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LS_SHUT && wr_en) |=> (locked && !wr_permit));
   assert_read_no_effect_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en) |=> $stable(state_q));
endmodule

// File: rtl/wlock_dout_bank.sv
module wlock_dout_bank #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              hit,
   input  logic              permit,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)                     q <= '0;
      else if (wr_en && hit && permit) q <= wdata;
   end

   assert_dout_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!permit && wr_en && hit) |=> $stable(q));
   assert_dout_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (permit && wr_en && hit) |=> (q == $past(wdata)));
endmodule

// File: rtl/wlock_guard.sv
module wlock_guard
   import wlock_pkg::*;
#(
   parameter int                ADDR_W     = 8,
   parameter int                DATA_W     = 32,
   parameter logic [ADDR_W-1:0] LOCK_A_OFS = 'h00,
   parameter logic [ADDR_W-1:0] LOCK_B_OFS = 'h7C,
   parameter logic [ADDR_W-1:0] DOUT_OFS   = 'h0C,
   parameter logic [DATA_W-1:0] KEY_FIRST  = 32'hC0DE1248,
   parameter logic [DATA_W-1:0] KEY_SECOND = 32'hC0DEFA73,
   parameter bit                RD_REG     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              wr_permit
);
   localparam int STAT_PAD = DATA_W - 1;

   if (LOCK_A_OFS == LOCK_B_OFS || LOCK_A_OFS == DOUT_OFS || LOCK_B_OFS == DOUT_OFS)
   begin : g_ofs_clash
      $error("wlock_guard: register offsets overlap");
   end
   if ((LOCK_A_OFS % 4) != 0 || (LOCK_B_OFS % 4) != 0 || (DOUT_OFS % 4) != 0)
   begin : g_ofs_align
      $error("wlock_guard: offsets must be word aligned");
   end
   if (DATA_W < 2) begin : g_width
      $error("wlock_guard: DATA_W too small");
   end

   logic              hit_a, hit_b, hit_d;
   logic              locked;
   logic [DATA_W-1:0] dout_q;
   logic [DATA_W-1:0] rd_mux;

   assign hit_a = (bus_addr == LOCK_A_OFS);
   assign hit_b = (bus_addr == LOCK_B_OFS);
   assign hit_d = (bus_addr == DOUT_OFS);

   wlock_keyseq #(
      .DATA_W(DATA_W), .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .hit_a(hit_a), .hit_b(hit_b),
      .wdata(bus_wdata), .locked(locked), .wr_permit(wr_permit)
   );

   wlock_dout_bank #(.DATA_W(DATA_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .hit(hit_d), .permit(wr_permit),
      .wdata(bus_wdata), .q(dout_q)
   );

   always_comb begin
      rd_mux = '0;
      if (hit_a)      rd_mux = {{STAT_PAD{1'b0}}, locked};
      else if (hit_d) rd_mux = dout_q;
   end

   if (RD_REG) begin : g_rd_reg
      always_ff @(posedge clk) begin
         if (!rst_n) bus_rdata <= '0;
         else        bus_rdata <= bus_rd ? rd_mux : '0;
      end
      assert_stat_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_rd && hit_a) |=> (bus_rdata == {{STAT_PAD{1'b0}}, !wr_permit}));
      assert_lockb_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_rd && hit_b) |=> (bus_rdata == '0));
      assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_rd && !hit_a && !hit_b && !hit_d) |=> (bus_rdata == '0));
   end else begin : g_rd_comb
      assign bus_rdata = bus_rd ? rd_mux : '0;
   end
endmodule

// File: tb/sim_wlock_guard.sv
module sim_wlock_guard;
   typedef struct packed {
      logic        rd;
      logic [7:0]  addr;
      logic [31:0] data;
      logic [31:0] exp;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 30;
   localparam logic [31:0] K1 = 32'hC0DE1248;
   localparam logic [31:0] K2 = 32'hC0DEFA73;
   // rd=1: exp is read data; rd=0: exp is wr_permit after the write
   localparam vec_t VEC [NV] = '{
      '{1'b1, 8'h00, 32'h0,        32'h0,        8'd4},  // R4 unlocked status
      '{1'b0, 8'h0C, 32'h98765432, 32'h1,        8'd5},  // R5
      '{1'b1, 8'h0C, 32'h0,        32'h98765432, 8'd5},  // R5
      '{1'b0, 8'h00, 32'h0,        32'h0,        8'd2},  // R2
      '{1'b1, 8'h00, 32'h0,        32'h1,        8'd4},  // R4 locked status
      '{1'b1, 8'h7C, 32'h0,        32'h0,        8'd4},  // R4 lock B reads 0
      '{1'b0, 8'h0C, 32'hA9876543, 32'h0,        8'd5},  // R5 dropped
      '{1'b1, 8'h0C, 32'h0,        32'h98765432, 8'd5},  // R5 kept
      '{1'b0, 8'h7C, K1,           32'h0,        8'd8},  // R8 first key only
      '{1'b1, 8'h00, 32'h0,        32'h1,        8'd8},  // R8 still reads 1
      '{1'b0, 8'h00, K2,           32'h1,        8'd9},  // R9 read between keys, R6
      '{1'b1, 8'h00, 32'h0,        32'h0,        8'd6},  // R6
      '{1'b0, 8'h0C, 32'hA9876543, 32'h1,        8'd5},  // R5
      '{1'b1, 8'h0C, 32'h0,        32'hA9876543, 8'd5},  // R5
      '{1'b0, 8'h7C, 32'h0,        32'h0,        8'd3},  // R3
      '{1'b1, 8'h00, 32'h0,        32'h1,        8'd3},  // R3
      '{1'b0, 8'h7C, K1,           32'h0,        8'd7},  // R7
      '{1'b0, 8'h00, 32'h12345678, 32'h0,        8'd7},  // R7 wrong value
      '{1'b0, 8'h00, K2,           32'h0,        8'd7},  // R7 no fresh first key
      '{1'b0, 8'h7C, K1,           32'h0,        8'd7},  // R7
      '{1'b0, 8'h0C, 32'h11111111, 32'h0,        8'd7},  // R7 intervening write
      '{1'b0, 8'h00, K2,           32'h0,        8'd7},  // R7
      '{1'b1, 8'h0C, 32'h0,        32'hA9876543, 8'd5},  // R5
      '{1'b0, 8'h7C, K1,           32'h0,        8'd7},  // R7
      '{1'b0, 8'h7C, K2,           32'h0,        8'd7},  // R7 wrong register
      '{1'b0, 8'h00, K2,           32'h0,        8'd7},  // R7
      '{1'b0, 8'h7C, K1,           32'h0,        8'd6},  // R6
      '{1'b0, 8'h00, K2,           32'h1,        8'd6},  // R6
      '{1'b1, 8'h40, 32'h0,        32'h0,        8'd10}, // R10 unmapped
      '{1'b1, 8'h0C, 32'h0,        32'hA9876543, 8'd10}  // R10 latency
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata;
   logic        wr_permit;
   int          total = 0;
   int          bad = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   wlock_guard #(.RD_REG(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .wr_permit(wr_permit)
   );

   task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL R%0d: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive at a falling edge, sample at the following falling edge
   task automatic access(input logic rd, input logic [7:0] a, input logic [31:0] d,
                         output logic [31:0] rdata, output logic permit);
      bus_addr  = a;
      bus_wdata = d;
      bus_rd    = rd;
      bus_wr    = !rd;
      @(negedge clk);
      bus_rd = 1'b0;
      bus_wr = 1'b0;
      rdata  = bus_rdata;
      permit = wr_permit;
   endtask

   initial begin
      logic [31:0] r;
      logic        p;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(1, {31'b0, wr_permit}, 32'h1);           // R1 permit after reset
      access(1'b1, 8'h0C, 32'h0, r, p);
      check(1, r, 32'h0);                            // R1 data-out cleared
      for (int i = 0; i < NV; i++) begin
         access(VEC[i].rd, VEC[i].addr, VEC[i].data, r, p);
         if (VEC[i].rd) check(int'(VEC[i].req), r, VEC[i].exp);
         else           check(int'(VEC[i].req), {31'b0, p}, VEC[i].exp);
      end
      // directed: lock again, then reset while locked (R1)
      access(1'b0, 8'h00, 32'hFFFFFFFF, r, p);
      check(2, {31'b0, p}, 32'h0);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(1, {31'b0, wr_permit}, 32'h1);
      access(1'b1, 8'h00, 32'h0, r, p);
      check(1, r, 32'h0);
      access(1'b1, 8'h0C, 32'h0, r, p);
      check(1, r, 32'h0);
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule